// File: doc/BRIEF.md
# Partitioned Cache Way Allocation Selector

This block sits in front of the replacement logic of a shared last-level cache. Each lookup presents a physical address. The address is compared against a small set of programmable access windows. The first enabled window that covers the address supplies a target identifier and a partition identifier.

The partition identifier is then tested, by bit position, against a bank of partition-set registers. Each partition-set register is paired with a way-mask register. The first set register that names the partition gives the ways the access may allocate into. A partition that no register names falls back to the shared pool. The shared pool is all ways with every dedicated way taken out.

The result is registered, one cycle after the request, together with the target identifier, a hit flag and a no-allocate flag. A simple write/read port holds the configuration. Tag lookup, victim choice within the allowed ways, data storage and address translation are done elsewhere.

Top module: `way_alloc_sel`

## Requirements
- R1: Configuration is written through `cfg_we_i`/`cfg_addr_i`/`cfg_wdata_i`. `cfg_addr_i[5:4]` selects the register kind: 0 is a window, 1 is a partition-set register, 2 is a way-mask register, 3 is unmapped. `cfg_addr_i[2:0]` selects the index. `cfg_rdata_o` returns the stored value combinationally, and an unmapped address reads as zero. After reset every register reads zero.
- R2: The window register layout is: bits [35:0] physical base, bits [41:36] log2 of the region size, bits [46:42] target ID, bits [51:47] partition ID, and bit 63 enable.
- R3: A window matches only the address bits at or above its log2 size. An address one byte past the region does not match, and the last byte inside the region does.
- R4: A window whose enable bit is 0 never matches.
- R5: When enabled windows overlap, the lowest-numbered one supplies the target and partition IDs.
- R6: An address that hits no window gives `hit_o`=0, `way_mask_o`=0 and `tgt_id_o`=0.
- R7: With every partition-set register zero, a hit allows all ways (`way_mask_o` all ones).
- R8: A partition-set register n whose bit p is set gives an access with partition ID p the mask held in way-mask register n.
- R9: When several partition-set registers name the same partition, the lowest-numbered one wins, and the masks are not merged.
- R10: A partition named by no register gets the default pool. The default pool is all ways minus the way masks of every non-zero partition-set register. It never contains a dedicated way.
- R11: A hit whose selected mask is zero raises `no_alloc_o`. `no_alloc_o` is never set on a miss.
- R12: Results appear on `valid_o` exactly one cycle after `req_valid_i`, and `valid_o` is 0 in any cycle that follows a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 6 | Configuration register address |
| cfg_wdata_i | input | 64 | Configuration write data |
| cfg_rdata_o | output | 64 | Configuration read data |
| req_valid_i | input | 1 | Lookup request valid |
| req_addr_i | input | 36 | Physical address of the lookup |
| valid_o | output | 1 | Lookup result valid |
| hit_o | output | 1 | Address hit an enabled window |
| tgt_id_o | output | 5 | Target ID of the winning window |
| way_mask_o | output | 16 | Ways the access may allocate into |
| no_alloc_o | output | 1 | Hit with an empty allowed-way mask |

## Verification
The bench builds the block with its default parameters: eight windows, eight partition register pairs, sixteen ways, a 36-bit address and 5-bit identifiers. Eight windows leave room for overlapping, disabled and out-of-range regions in one configuration. Eight register pairs allow two registers to claim the same partition while a third one empties the default pool. Sixteen ways allow dedicated masks in separate nibbles, so a merged or wrongly chosen mask shows up as a different value.

// File: rtl/wa_pkg.sv
package wa_pkg;
  localparam int CFG_DW = 64;
  localparam int PA_W   = 36;
  localparam int PID_W  = 5;
  localparam int TID_W  = 5;
  localparam int SZ_W   = 6;

  typedef struct packed {
    logic              en;
    logic [10:0]       rsvd;
    logic [PID_W-1:0]  pid;
    logic [TID_W-1:0]  tid;
    logic [SZ_W-1:0]   size_log2;
    logic [PA_W-1:0]   base;
  } win_cfg_t;

  typedef enum logic [1:0] {
    KIND_WIN  = 2'd0,
    KIND_PSET = 2'd1,
    KIND_WAYS = 2'd2,
    KIND_NONE = 2'd3
  } cfg_kind_e;
endpackage

// File: rtl/wa_win_dec.sv
module wa_win_dec
  import wa_pkg::*;
#(
  parameter int N_WIN = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  win_cfg_t [N_WIN-1:0]  win_i,
  input  logic [PA_W-1:0]       addr_i,
  output logic                  hit_o,
  output logic [TID_W-1:0]      tid_o,
  output logic [PID_W-1:0]      pid_o
);
  logic [N_WIN-1:0] match;
  logic [N_WIN-1:0] grant;

  for (genvar i = 0; i < N_WIN; i++) begin : g_win
    logic [PA_W-1:0] cmp_mask;
    always_comb begin
      if (int'(win_i[i].size_log2) >= PA_W) cmp_mask = '0;
      else cmp_mask = {PA_W{1'b1}} << win_i[i].size_log2;
      match[i] = win_i[i].en && (((addr_i ^ win_i[i].base) & cmp_mask) == '0);
    end
  end

  // lowest index wins
  always_comb begin
    grant = '0;
    hit_o = 1'b0;
    tid_o = '0;
    pid_o = '0;
    for (int i = N_WIN - 1; i >= 0; i--) begin
      if (match[i]) begin
        grant = '0;
        grant[i] = 1'b1;
        hit_o = 1'b1;
        tid_o = win_i[i].tid;
        pid_o = win_i[i].pid;
      end
    end
  end

  // R5
  win_grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant) && (hit_o == (match != '0)));
endmodule

// File: rtl/wa_part_sel.sv
module wa_part_sel
  import wa_pkg::*;
#(
  parameter int N_PART = 8,
  parameter int N_WAYS = 16
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [N_PART-1:0][(1<<PID_W)-1:0]   pset_i,
  input  logic [N_PART-1:0][N_WAYS-1:0]       ways_i,
  input  logic [PID_W-1:0]                    pid_i,
  output logic [N_WAYS-1:0]                   mask_o
);
  logic [N_WAYS-1:0] dedicated;
  logic [N_WAYS-1:0] dflt_mask;
  logic [N_PART-1:0] sel;
  logic              claimed;

  always_comb begin
    dedicated = '0;
    for (int j = 0; j < N_PART; j++)
      if (pset_i[j] != '0) dedicated |= ways_i[j];
    dflt_mask = ~dedicated;
  end

  always_comb begin
    sel     = '0;
    claimed = 1'b0;
    mask_o  = dflt_mask;
    for (int j = N_PART - 1; j >= 0; j--) begin
      if (pset_i[j][pid_i]) begin
        sel      = '0;
        sel[j]   = 1'b1;
        claimed  = 1'b1;
        mask_o   = ways_i[j];
      end
    end
  end

  // R9
  part_sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel) && (claimed == (sel != '0)));
  // R10
  dflt_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !claimed |-> ((mask_o & dedicated) == '0));
endmodule

// File: rtl/way_alloc_sel.sv
module way_alloc_sel
  import wa_pkg::*;
#(
  parameter int N_WIN  = 8,
  parameter int N_PART = 8,
  parameter int N_WAYS = 16,
  parameter int CFG_AW = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [CFG_AW-1:0]    cfg_addr_i,
  input  logic [CFG_DW-1:0]    cfg_wdata_i,
  output logic [CFG_DW-1:0]    cfg_rdata_o,
  input  logic                 req_valid_i,
  input  logic [PA_W-1:0]      req_addr_i,
  output logic                 valid_o,
  output logic                 hit_o,
  output logic [TID_W-1:0]     tgt_id_o,
  output logic [N_WAYS-1:0]    way_mask_o,
  output logic                 no_alloc_o
);
  localparam int IDX_W   = 3;
  localparam int PSET_W  = 1 << PID_W;

  win_cfg_t [N_WIN-1:0]               win_q;
  logic [N_PART-1:0][PSET_W-1:0]      pset_q;
  logic [N_PART-1:0][N_WAYS-1:0]      ways_q;

  cfg_kind_e        kind;
  logic [IDX_W-1:0] idx;
  assign kind = cfg_kind_e'(cfg_addr_i[5:4]);
  assign idx  = cfg_addr_i[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      pset_q <= '0;
      ways_q <= '0;
    end else if (cfg_we_i) begin
      unique case (kind)
        KIND_WIN:  if (int'(idx) < N_WIN)  win_q[idx]  <= win_cfg_t'(cfg_wdata_i);
        KIND_PSET: if (int'(idx) < N_PART) pset_q[idx] <= cfg_wdata_i[PSET_W-1:0];
        KIND_WAYS: if (int'(idx) < N_PART) ways_q[idx] <= cfg_wdata_i[N_WAYS-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    cfg_rdata_o = '0;
    unique case (kind)
      KIND_WIN:  if (int'(idx) < N_WIN)  cfg_rdata_o = CFG_DW'(win_q[idx]);
      KIND_PSET: if (int'(idx) < N_PART) cfg_rdata_o = CFG_DW'(pset_q[idx]);
      KIND_WAYS: if (int'(idx) < N_PART) cfg_rdata_o = CFG_DW'(ways_q[idx]);
      default: ;
    endcase
  end

  logic               dec_hit;
  logic [TID_W-1:0]   dec_tid;
  logic [PID_W-1:0]   dec_pid;
  logic [N_WAYS-1:0]  sel_mask;

  wa_win_dec #(.N_WIN(N_WIN)) u_win_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .win_i  (win_q),
    .addr_i (req_addr_i),
    .hit_o  (dec_hit),
    .tid_o  (dec_tid),
    .pid_o  (dec_pid)
  );

  wa_part_sel #(.N_PART(N_PART), .N_WAYS(N_WAYS)) u_part_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pset_i (pset_q),
    .ways_i (ways_q),
    .pid_i  (dec_pid),
    .mask_o (sel_mask)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      hit_o      <= 1'b0;
      tgt_id_o   <= '0;
      way_mask_o <= '0;
      no_alloc_o <= 1'b0;
    end else begin
      valid_o <= req_valid_i;
      if (req_valid_i) begin
        hit_o      <= dec_hit;
        tgt_id_o   <= dec_hit ? dec_tid : '0;
        way_mask_o <= dec_hit ? sel_mask : '0;
        no_alloc_o <= dec_hit && (sel_mask == '0);
      end
    end
  end

  // R12
  lat_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> valid_o);
  // R12
  lat_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !valid_o);
  // R6
  miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !hit_o) |-> (way_mask_o == '0 && tgt_id_o == '0 && !no_alloc_o));
  // R11
  no_alloc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_alloc_o |-> (hit_o && way_mask_o == '0));
endmodule

// File: tb/way_alloc_sel_tb_top.sv
module way_alloc_sel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [63:0] cfg_wdata = '0;
  logic [63:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [35:0] req_addr = '0;
  logic        valid, hit, no_alloc;
  logic [4:0]  tgt_id;
  logic [15:0] way_mask;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  way_alloc_sel dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .req_valid_i(req_valid), .req_addr_i(req_addr),
    .valid_o(valid), .hit_o(hit), .tgt_id_o(tgt_id), .way_mask_o(way_mask), .no_alloc_o(no_alloc)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] win_word(input logic en, input logic [4:0] pid,
      input logic [4:0] tid, input logic [5:0] sz, input logic [35:0] base);
    return {en, 11'b0, pid, tid, sz, base};
  endfunction

  task automatic wr(input logic [5:0] a, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic lookup(input logic [35:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_res(input string tag, input logic h, input logic [4:0] t,
      input logic [15:0] m, input logic na);
    check({tag, " valid"}, 64'(valid), 64'(1'b1));
    check({tag, " hit"}, 64'(hit), 64'(h));
    check({tag, " tgt"}, 64'(tgt_id), 64'(t));
    check({tag, " mask"}, 64'(way_mask), 64'(m));
    check({tag, " no_alloc"}, 64'(no_alloc), 64'(na));
  endtask

  task automatic t_reset;
    check("R1 reset rdata win0", cfg_rdata, 64'h0);
    cfg_addr = 6'h12;
    #1 check("R1 reset rdata pset2", cfg_rdata, 64'h0);
    check("R12 reset valid", 64'(valid), 64'h0);
  endtask

  task automatic t_cfg_and_all_ways;
    logic [63:0] w0;
    w0 = win_word(1'b1, 5'd2, 5'd3, 6'd28, 36'h0_8000_0000);
    wr(6'h00, w0);
    cfg_addr = 6'h00;
    #1 check("R1 R2 window readback", cfg_rdata, w0);
    cfg_addr = 6'h30;
    #1 check("R1 unmapped reads zero", cfg_rdata, 64'h0);
    lookup(36'h0_8123_4567);
    expect_res("R7 unconfigured all ways", 1'b1, 5'd3, 16'hFFFF, 1'b0);
  endtask

  task automatic t_miss_and_bounds;
    lookup(36'h1_0000_0000);
    expect_res("R6 miss", 1'b0, 5'd0, 16'h0, 1'b0);
    lookup(36'h0_9000_0000);
    expect_res("R3 one past region", 1'b0, 5'd0, 16'h0, 1'b0);
    lookup(36'h0_8FFF_FFFF);
    expect_res("R3 last byte", 1'b1, 5'd3, 16'hFFFF, 1'b0);
  endtask

  task automatic t_disabled;
    wr(6'h02, win_word(1'b0, 5'd1, 5'd7, 6'd20, 36'h1_0000_0000));
    lookup(36'h1_0000_0040);
    expect_res("R4 disabled window", 1'b0, 5'd0, 16'h0, 1'b0);
  endtask

  task automatic t_overlap;
    wr(6'h03, win_word(1'b1, 5'd4, 5'd9, 6'd30, 36'h0_8000_0000));
    lookup(36'h0_8000_0010);
    expect_res("R5 overlap lower wins", 1'b1, 5'd3, 16'hFFFF, 1'b0);
    lookup(36'h0_A000_0000);
    expect_res("R5 outer window only", 1'b1, 5'd9, 16'hFFFF, 1'b0);
  endtask

  task automatic t_partition;
    wr(6'h11, 64'h4);
    wr(6'h21, 64'h000F);
    lookup(36'h0_8000_0100);
    expect_res("R8 pid2 via reg1", 1'b1, 5'd3, 16'h000F, 1'b0);
    lookup(36'h0_A000_0000);
    expect_res("R10 pid4 default pool", 1'b1, 5'd9, 16'hFFF0, 1'b0);
  endtask

  task automatic t_lowest_wins;
    wr(6'h10, 64'h14);
    wr(6'h20, 64'h00F0);
    wr(6'h04, win_word(1'b1, 5'd7, 5'd1, 6'd12, 36'h2_0000_0000));
    lookup(36'h0_8000_0100);
    expect_res("R9 pid2 lowest reg", 1'b1, 5'd3, 16'h00F0, 1'b0);
    lookup(36'h0_A000_0000);
    expect_res("R9 pid4 reg0", 1'b1, 5'd9, 16'h00F0, 1'b0);
    lookup(36'h2_0000_0FFF);
    expect_res("R10 pid7 default minus both", 1'b1, 5'd1, 16'hFF00, 1'b0);
  endtask

  task automatic t_no_alloc;
    wr(6'h12, 64'h200);
    wr(6'h22, 64'hFF00);
    lookup(36'h2_0000_0004);
    expect_res("R11 empty default", 1'b1, 5'd1, 16'h0000, 1'b1);
    lookup(36'h3_0000_0000);
    expect_res("R11 miss no flag", 1'b0, 5'd0, 16'h0, 1'b0);
  endtask

  task automatic t_latency;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 36'h0_8000_0000;
    @(negedge clk);
    req_valid = 1'b0;
    check("R12 valid one cycle later", 64'(valid), 64'h1);
    @(negedge clk);
    check("R12 valid drops after idle", 64'(valid), 64'h0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_cfg_and_all_ways();
        t_miss_and_bounds();
        t_disabled();
        t_overlap();
        t_partition();
        t_lowest_wins();
        t_no_alloc();
        t_latency();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule